// File: doc/BRIEF.md
# Ring Phase Sampler and Toggle-Count Frequency Detector

This block sits behind a multi-phase ring oscillator, one that serves as a quantizer, and turns the oscillator's stage outputs into two digital codes on each rising edge of the reference clock. The first code is the phase code. It is the ring state as the block saw it at a sample instant, passed through a synchronizer and then registered. The second code is the frequency code. For each stage it marks whether that stage changed level between the previous snapshot and the current one.

The frequency information comes from comparing two consecutive snapshots of the whole ring, not from counting oscillator cycles. The set of stages that toggle therefore moves around the ring on its own as the oscillator runs, so a later digital-to-analog stage can use this code without any extra element rotation. The phase code does not have this property and needs rotation further downstream. A binary count of the toggled stages is also provided. Its range runs from zero up to the number of stages. A valid flag stays low until the comparison uses two real post-reset snapshots.

Top module: `ring_phase_freq_det`

## Requirements
- R1: While reset is low at a clock edge, that edge clears the phase code, the toggle vector and the toggle count to zero and drives the valid flag low.
- R2: The phase code equals the ring input vector as sampled two clock edges earlier. The synchronizer is two stages deep.
- R3: While valid is high, toggle vector bit i is 1 exactly when bit i of the phase code differs from its value one edge earlier.
- R4: The toggle count is the number of ones in the toggle vector, in unsigned binary, with a range from 0 to 15.
- R5: The valid flag goes high on the third clock edge after reset is released and then stays high until the next reset.
- R6: If a modelled ring advances by k stages per sample, with 0 ≤ k ≤ 15, the valid toggle count equals k. This includes a stalled ring (0) and a half-period jump (15, all stages toggle).
- R7: If reset is asserted in the middle of operation, the outputs clear and the valid flag goes low again. After release the valid flag returns with the same three-edge delay as in R5.
- R8: While the ring advances by a constant step, the toggled stages move around the ring. With a step of 4 over 15 consecutive valid samples, every stage toggles exactly 4 times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_phase_i | input | 15 | Asynchronous ring stage levels |
| phase_code_o | output | 15 | Synchronized, registered ring snapshot |
| freq_vec_o | output | 15 | Per-stage toggle marks between consecutive snapshots |
| freq_count_o | output | 4 | Number of toggled stages |
| freq_valid_o | output | 1 | Toggle outputs are based on two real snapshots |

## Verification
The hardest conditions to reach from the ports are the two extreme advances: every stage toggling at once, and a ring that does not move at all. A third is a reset that arrives in the middle of a run while the snapshot pipeline is full. The stimulus drives a modelled ring position that moves around a 30-step cycle with a chosen step each cycle. The steps include 0, 15 and the values between them, so the exact number of flipped stages is known. A scoreboard queue holds every driven snapshot together with its step. A second reset is issued partway through the run, and the bench checks that the valid flag recovers after that reset.

// File: rtl/rpf_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the ring phase sampler.
// Assumes: stage counts are small (well under 64).
package rpf_pkg;
    // Width needed to hold a count from 0 up to n inclusive.
    function automatic int unsigned rpf_count_w(input int unsigned n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/rpf_sync_chain.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a vector of asynchronous ring levels.
// Assumes: DEPTH >= 1; the output is the last register of the chain.
module rpf_sync_chain #(
    parameter int unsigned WIDTH = 15,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [DEPTH];

    generate
        for (genvar d = 0; d < DEPTH; d++) begin : g_stage
            if (d == 0) begin : g_first
                // Capture the raw ring levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= din;
                end
            end else begin : g_next
                // Pass the snapshot one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[d] <= '0;
                    else        stage_q[d] <= stage_q[d-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/rpf_toggle_detect.sv
`timescale 1ns/1ps
// Holds the previous snapshot and marks stages whose level changed.
// Assumes: cur is a registered snapshot; FILL_CYCLES edges after reset
// release, prev holds a real snapshot and the marks become valid.
module rpf_toggle_detect #(
    parameter int unsigned WIDTH       = 15,
    parameter int unsigned FILL_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] toggled,
    output logic             valid
);
    localparam int unsigned FW = $clog2(FILL_CYCLES + 1);

    logic [WIDTH-1:0] prev_q;
    logic [FW-1:0]    fill_q;

    // Delay the snapshot by one edge; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    // Count edges since reset release, saturating at the fill depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                         fill_q <= '0;
        else if (fill_q != FW'(FILL_CYCLES)) fill_q <= fill_q + 1'b1;
    end

    // Per-stage change marks between consecutive snapshots.
    always_comb toggled = cur ^ prev_q;

    // Valid once the pipeline is filled with real samples.
    always_comb valid = (fill_q == FW'(FILL_CYCLES));
endmodule

// File: rtl/rpf_popcount.sv
`timescale 1ns/1ps
// Counts the ones in a vector.
// Assumes: CW is wide enough to hold WIDTH.
module rpf_popcount #(
    parameter int unsigned WIDTH = 15,
    parameter int unsigned CW    = 4
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CW-1:0]    count
);
    // Sum the set bits one stage at a time.
    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) count = count + CW'(vec[i]);
    end
endmodule

// File: rtl/ring_phase_freq_det.sv
`timescale 1ns/1ps
// Ring phase sampler and frequency detector.
// Samples all ring stage levels each reference edge through a
// synchronizer, presents the snapshot as the phase code, and marks
// stages that changed since the previous snapshot as the frequency code,
// with a binary count of those marks.
// Assumes: ring levels are asynchronous to clk; reset is synchronous.
module ring_phase_freq_det #(
    parameter int unsigned STAGES     = 15,
    parameter int unsigned SYNC_DEPTH = 2,
    localparam int unsigned CNT_W     = rpf_pkg::rpf_count_w(STAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] ring_phase_i,
    output logic [STAGES-1:0] phase_code_o,
    output logic [STAGES-1:0] freq_vec_o,
    output logic [CNT_W-1:0]  freq_count_o,
    output logic              freq_valid_o
);
    localparam int unsigned FILL = SYNC_DEPTH + 1;

    rpf_sync_chain #(.WIDTH(STAGES), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ring_phase_i),
        .dout (phase_code_o)
    );

    rpf_toggle_detect #(.WIDTH(STAGES), .FILL_CYCLES(FILL)) u_toggle (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur    (phase_code_o),
        .toggled(freq_vec_o),
        .valid  (freq_valid_o)
    );

    rpf_popcount #(.WIDTH(STAGES), .CW(CNT_W)) u_count (
        .vec  (freq_vec_o),
        .count(freq_count_o)
    );
endmodule

// File: rtl/rpf_checker.sv
`timescale 1ns/1ps
// Temporal checks on the ring phase sampler, bound to its top module.
// Assumes: synchronous active-low reset.
module rpf_checker #(
    parameter int unsigned STAGES     = 15,
    parameter int unsigned SYNC_DEPTH = 2,
    parameter int unsigned CNT_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAGES-1:0] ring_phase_i,
    input logic [STAGES-1:0] phase_code_o,
    input logic [STAGES-1:0] freq_vec_o,
    input logic [CNT_W-1:0]  freq_count_o,
    input logic              freq_valid_o
);
    localparam int unsigned FILL = SYNC_DEPTH + 1;
    logic [3:0] cyc_q;

    // Edges since reset release, saturating at 15.
    always_ff @(posedge clk) begin
        if (!rst_n)              cyc_q <= '0;
        else if (cyc_q != 4'hF)  cyc_q <= cyc_q + 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (phase_code_o == '0 && freq_vec_o == '0 && !freq_valid_o));

    assert_phase_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 4'd2) |-> (phase_code_o == $past(ring_phase_i, 2)));

    assert_toggle_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        freq_valid_o |-> (freq_vec_o == (phase_code_o ^ $past(phase_code_o))));

    assert_count_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        freq_valid_o |-> (32'(freq_count_o) == $countones(freq_vec_o)));

    assert_valid_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        freq_valid_o == (32'(cyc_q) >= FILL));

    assert_valid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        freq_valid_o |=> freq_valid_o);
endmodule

bind ring_phase_freq_det rpf_checker #(
    .STAGES(STAGES), .SYNC_DEPTH(SYNC_DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ring_phase_i(ring_phase_i),
    .phase_code_o(phase_code_o), .freq_vec_o(freq_vec_o),
    .freq_count_o(freq_count_o), .freq_valid_o(freq_valid_o)
);

// File: tb/sim_ring_phase_freq_det.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes each driven ring snapshot with its
// step; the monitor pops and compares after each clock edge.
module sim_ring_phase_freq_det;
    localparam int N = 15;

    typedef struct {
        logic [N-1:0] vec;
        int           step;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] ring = '0;
    logic [N-1:0] phase_code, freq_vec;
    logic [3:0]   freq_count;
    logic         freq_valid;

    int errors = 0;
    int checks = 0;
    int pos = 0;
    bit done = 0;
    item_t q[$];

    always #5 clk = ~clk;

    ring_phase_freq_det u0 (
        .clk(clk), .rst_n(rst_n), .ring_phase_i(ring),
        .phase_code_o(phase_code), .freq_vec_o(freq_vec),
        .freq_count_o(freq_count), .freq_valid_o(freq_valid)
    );

    // Modelled ring level pattern at position p of a 2N-step cycle.
    function automatic logic [N-1:0] pattern(input int p);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (p < N) ? (i < p) : (i >= p - N);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: advance the ring by k stages and record the expectation.
    task automatic drive_step(input int k);
        item_t it;
        @(negedge clk);
        pos = (pos + k) % (2 * N);
        ring = pattern(pos);
        it.vec = ring;
        it.step = k;
        q.push_back(it);
    endtask

    task automatic enter_reset(input int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        q.delete();
        repeat (cycles) begin
            @(negedge clk);
            pos = (pos + 2) % (2 * N);
            ring = pattern(pos);
        end
    endtask

    task automatic release_reset();
        item_t it;
        @(negedge clk);
        rst_n = 1'b1;
        it.vec = ring;
        it.step = 0;
        q.push_back(it);
    endtask

    // Monitor: compare outputs shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst_n) begin
                check(phase_code == '0 && freq_vec == '0 && freq_count == 0,
                      "R1", "reset clear", int'(phase_code), 0);
                check(!freq_valid, "R1", "reset valid", int'(freq_valid), 0);
            end else begin
                while (q.size() > 3) void'(q.pop_front());
                if (q.size() == 1) begin
                    check(phase_code == '0, "R2", "phase before fill", int'(phase_code), 0);
                    check(!freq_valid, "R5", "valid after 1 edge", int'(freq_valid), 0);
                end else if (q.size() == 2) begin
                    check(phase_code == q[0].vec, "R2", "phase", int'(phase_code), int'(q[0].vec));
                    check(!freq_valid, "R5", "valid after 2 edges", int'(freq_valid), 0);
                end else if (q.size() == 3) begin
                    check(phase_code == q[1].vec, "R2", "phase", int'(phase_code), int'(q[1].vec));
                    check(freq_valid, "R5", "valid high", int'(freq_valid), 1);
                    check(freq_vec == (q[1].vec ^ q[0].vec), "R3", "toggle vector",
                          int'(freq_vec), int'(q[1].vec ^ q[0].vec));
                    check(freq_count == $countones(freq_vec), "R4", "count of ones",
                          int'(freq_count), $countones(freq_vec));
                    check(int'(freq_count) == q[1].step, "R6", "count equals advance",
                          int'(freq_count), q[1].step);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int tally [N];
        enter_reset(3);
        release_reset();
        // R6: a range of fixed and mixed advances, including stall and half period.
        repeat (8) drive_step(1);
        repeat (8) drive_step(3);
        repeat (6) drive_step(7);
        repeat (4) drive_step(0);
        repeat (4) drive_step(15);
        repeat (4) drive_step(14);
        for (int k = 0; k <= N; k++) drive_step(k);
        // R7: reset in the middle of a full pipeline, then recovery.
        enter_reset(2);
        release_reset();
        repeat (6) drive_step(5);
        // R8: constant step of 4; each stage toggles 4 times over 15 samples.
        repeat (5) drive_step(4);
        for (int i = 0; i < N; i++) tally[i] = 0;
        for (int c = 0; c < N; c++) begin
            drive_step(4);
            for (int i = 0; i < N; i++) tally[i] += int'(freq_vec[i]);
        end
        for (int i = 0; i < N; i++)
            check(tally[i] == 4, "R8", $sformatf("toggles of stage %0d", i), tally[i], 4);
        repeat (3) drive_step(2);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule